// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This unit executes the multiply and divide operations of a register-based processor over several clock cycles. A single-cycle `start` strobe presents an operation (multiply or divide), a signedness choice and an operand size (byte or word), together with the current destination register contents and a source operand. When the work is finished the unit presents the new destination value with a one-cycle `done` strobe, plus zero and negative indications for the result.

Multiplication yields a double-width product using one shift-add step per multiplier bit. Division takes a double-width dividend from the destination and a single-width divisor from the source. It returns the remainder in the upper half of the destination field and the quotient in the lower half. It uses one restoring step per dividend bit, so the remainder is always exact and the quotient's low bits are exact even when the quotient does not fit. Signed operations work on magnitudes, and the signs are restored in a final cycle. A zero divisor ends the operation at once, without entering the loop.

Top module: `mdu_unit`

## Requirements
- R1: Unsigned multiply, byte size: `dst_in[7:0]*src_in[7:0]` appears in `result[15:0]` and `result[31:16]` equals `dst_in[31:16]`. Unsigned multiply, word size: `result = dst_in[15:0]*src_in[15:0]` (32 bits).
- R2: With `op_signed=1`, multiply treats both operands as two's complement at the selected size and returns the two's complement product in the same fields as R1.
- R3: Unsigned divide, byte size: the dividend is `dst_in[15:0]` and the divisor is `src_in[7:0]`, giving `result = {dst_in[31:16], remainder[7:0], quotient[7:0]}`. Unsigned divide, word size: the dividend is `dst_in[31:0]` and the divisor is `src_in[15:0]`, giving `result = {remainder[15:0], quotient[15:0]}`.
- R4: Signed divide rounds the quotient toward zero, and a nonzero remainder takes the sign of the dividend.
- R5: A quotient too wide for its field is not flagged. Its low 8 or 16 bits are returned and the remainder is still exact.
- R6: A start accepted while idle raises `busy` from the next cycle. `done` rises S+1 cycles after the accepting edge, where S is 8 (byte multiply), 16 (word multiply or byte divide) or 32 (word divide). `busy` falls in the same cycle that `done` rises.
- R7: A divide with a zero divisor (the `src_in` field of the selected size) completes in the next cycle with `done=1` and `div_zero=1` and `result=dst_in`. `busy` never rises, and `res_zero`/`res_neg` keep their previous values.
- R8: `start` while `busy` is high is ignored. The operation in progress is unaffected and no extra completion occurs.
- R9: `done` and `div_zero` are single-cycle strobes, and `div_zero` is low on every normal completion.
- R10: On normal completion, `res_zero` and `res_neg` describe the product (multiply) or the quotient (divide) at the selected width: all bits zero, and the top bit of that field. They hold until the next normal completion.
- R11: After reset, `busy`, `done`, `div_zero`, `res_zero`, `res_neg` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request strobe |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| op_signed | input | 1 | 1 = two's complement operands |
| op_word | input | 1 | 1 = word size, 0 = byte size |
| dst_in | input | 32 | Destination register contents (multiplicand or dividend) |
| src_in | input | 16 | Source operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion strobe |
| div_zero | output | 1 | Divide-by-zero strobe, valid with done |
| result | output | 32 | New destination value |
| res_zero | output | 1 | Result field is zero |
| res_neg | output | 1 | Top bit of the result field |

## Verification
Directed multiplies use all-ones, most-negative and mixed-sign operands. They separate an unsigned treatment of the operands from a signed one, and expose sign fix-up errors at both sizes. Directed divides with positive and negative dividends and divisors show whether the quotient is truncated toward zero and which sign the remainder takes. Divides whose quotients overflow the field show whether the loop runs over the full dividend width. Zero divisors, starts issued while busy and starts issued in the completion cycle exercise the control paths. A long run of random operations, compared cycle by cycle against an integer model, covers the operand patterns between these cases.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mdu_state_e;
endpackage

// File: rtl/mdu_prep.sv
// Operand preparation: sign handling, magnitudes, loop seeds and step count.
module mdu_prep #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W,
  localparam int DST_W  = 4 * HALF_W,
  localparam int CNT_W  = $clog2(2 * WORD_W + 1)
) (
  input  logic              op_div,
  input  logic              op_signed,
  input  logic              op_word,
  input  logic [DST_W-1:0]  dst_in,
  input  logic [WORD_W-1:0] src_in,
  output logic [DST_W-1:0]  seed_acc,
  output logic [WORD_W-1:0] seed_opnd,
  output logic              neg_main,
  output logic              neg_rem,
  output logic              divisor_zero,
  output logic [CNT_W-1:0]  steps
);

  function automatic logic [WORD_W-1:0] widen(input logic [HALF_W-1:0] v, input logic sgn);
    return {{HALF_W{sgn & v[HALF_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] mag_word(input logic [WORD_W-1:0] v, input logic neg);
    return neg ? (~v + WORD_W'(1)) : v;
  endfunction

  function automatic logic [DST_W-1:0] mag_dst(input logic [DST_W-1:0] v, input logic neg);
    return neg ? (~v + DST_W'(1)) : v;
  endfunction

  logic [WORD_W-1:0] d_half, s_half, a_mag, b_mag;
  logic [DST_W-1:0]  d_full, dvd_mag;
  logic              a_neg, b_neg;

  always_comb begin
    d_half  = op_word ? dst_in[WORD_W-1:0] : widen(dst_in[HALF_W-1:0], op_signed);
    s_half  = op_word ? src_in : widen(src_in[HALF_W-1:0], op_signed);
    d_full  = op_word ? dst_in
                      : {{WORD_W{op_signed & dst_in[WORD_W-1]}}, dst_in[WORD_W-1:0]};
    a_neg   = op_signed & (op_div ? d_full[DST_W-1] : d_half[WORD_W-1]);
    b_neg   = op_signed & s_half[WORD_W-1];
    a_mag   = mag_word(d_half, a_neg);
    b_mag   = mag_word(s_half, b_neg);
    dvd_mag = mag_dst(d_full, a_neg);
    neg_main     = a_neg ^ b_neg;
    neg_rem      = a_neg;
    divisor_zero = (s_half == '0);
    if (op_div) begin
      seed_acc  = op_word ? dvd_mag : (dvd_mag << WORD_W);
      seed_opnd = b_mag;
      steps     = op_word ? CNT_W'(2 * WORD_W) : CNT_W'(WORD_W);
    end else begin
      seed_acc  = {{WORD_W{1'b0}}, b_mag};
      seed_opnd = a_mag;
      steps     = op_word ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
    end
  end

endmodule

// File: rtl/mdu_engine.sv
// Iterative datapath: one shift-add or one restoring-divide step per cycle.
module mdu_engine #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W,
  localparam int DST_W  = 4 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              mode_div,
  input  logic [DST_W-1:0]  seed_acc,
  input  logic [WORD_W-1:0] seed_opnd,
  output logic [DST_W-1:0]  prod_word,
  output logic [WORD_W-1:0] prod_byte,
  output logic [WORD_W-1:0] quot_mag,
  output logic [WORD_W-1:0] rem_mag
);

  logic [WORD_W:0]   hi_q, hi_d;
  logic [DST_W-1:0]  lo_q, lo_d;
  logic [WORD_W-1:0] opnd_q;

  // multiply step
  logic [WORD_W:0]   sum;
  // divide step
  logic [WORD_W:0]   shifted;
  logic [WORD_W+1:0] diff;
  logic              fits;

  always_comb begin
    sum     = hi_q + (lo_q[0] ? {1'b0, opnd_q} : '0);
    shifted = {hi_q[WORD_W-1:0], lo_q[DST_W-1]};
    diff    = {1'b0, shifted} - {2'b00, opnd_q};
    fits    = ~diff[WORD_W+1];
    if (mode_div) begin
      hi_d = fits ? diff[WORD_W:0] : shifted;
      lo_d = {lo_q[DST_W-2:0], fits};
    end else begin
      hi_d = {1'b0, sum[WORD_W:1]};
      lo_d = {lo_q[DST_W-1:WORD_W], sum[0], lo_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
    end else if (load) begin
      hi_q   <= '0;
      lo_q   <= seed_acc;
      opnd_q <= seed_opnd;
    end else if (step) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign prod_word = {hi_q[WORD_W-1:0], lo_q[WORD_W-1:0]};
  assign prod_byte = {hi_q[HALF_W-1:0], lo_q[WORD_W-1:HALF_W]};
  assign quot_mag  = lo_q[WORD_W-1:0];
  assign rem_mag   = hi_q[WORD_W-1:0];

endmodule

// File: rtl/mdu_ctrl.sv
// Sequencer: idle / iterate / sign fix-up.
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             trap,
  input  logic [CNT_W-1:0] steps,
  output logic             busy,
  output logic             accept,
  output logic             stepping,
  output logic             finishing
);

  mdu_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept    = start && (state_q == ST_IDLE);
  assign stepping  = (state_q == ST_RUN);
  assign finishing = (state_q == ST_FIX);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !trap) begin
          state_q <= ST_RUN;
          cnt_q   <= steps;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W,
  localparam int DST_W  = 4 * HALF_W,
  localparam int CNT_W  = $clog2(2 * WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_div,
  input  logic              op_signed,
  input  logic              op_word,
  input  logic [DST_W-1:0]  dst_in,
  input  logic [WORD_W-1:0] src_in,
  output logic              busy,
  output logic              done,
  output logic              div_zero,
  output logic [DST_W-1:0]  result,
  output logic              res_zero,
  output logic              res_neg
);

  logic [DST_W-1:0]  seed_acc;
  logic [WORD_W-1:0] seed_opnd;
  logic              neg_main, neg_rem, divisor_zero;
  logic [CNT_W-1:0]  steps;

  // named events
  logic accept, zero_trap, stepping, finishing;

  mdu_prep #(.HALF_W(HALF_W)) u_prep (
    .op_div       (op_div),
    .op_signed    (op_signed),
    .op_word      (op_word),
    .dst_in       (dst_in),
    .src_in       (src_in),
    .seed_acc     (seed_acc),
    .seed_opnd    (seed_opnd),
    .neg_main     (neg_main),
    .neg_rem      (neg_rem),
    .divisor_zero (divisor_zero),
    .steps        (steps)
  );

  assign zero_trap = accept && op_div && divisor_zero;

  mdu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .trap      (op_div && divisor_zero),
    .steps     (steps),
    .busy      (busy),
    .accept    (accept),
    .stepping  (stepping),
    .finishing (finishing)
  );

  // operation context captured at acceptance
  logic              div_q, word_q, neg_main_q, neg_rem_q;
  logic [WORD_W-1:0] dst_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= 1'b0;
      word_q     <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      dst_hi_q   <= '0;
    end else if (accept) begin
      div_q      <= op_div;
      word_q     <= op_word;
      neg_main_q <= neg_main;
      neg_rem_q  <= neg_rem;
      dst_hi_q   <= dst_in[DST_W-1:WORD_W];
    end
  end

  logic [DST_W-1:0]  prod_word;
  logic [WORD_W-1:0] prod_byte, quot_mag, rem_mag;

  mdu_engine #(.HALF_W(HALF_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && !zero_trap),
    .step      (stepping),
    .mode_div  (div_q),
    .seed_acc  (seed_acc),
    .seed_opnd (seed_opnd),
    .prod_word (prod_word),
    .prod_byte (prod_byte),
    .quot_mag  (quot_mag),
    .rem_mag   (rem_mag)
  );

  function automatic logic [DST_W-1:0] fix_dst(input logic [DST_W-1:0] v, input logic neg);
    return neg ? (~v + DST_W'(1)) : v;
  endfunction

  function automatic logic [WORD_W-1:0] fix_word(input logic [WORD_W-1:0] v, input logic neg);
    return neg ? (~v + WORD_W'(1)) : v;
  endfunction

  logic [DST_W-1:0]  prod_s, packed_res;
  logic [WORD_W-1:0] quot_s, rem_s;
  logic              pack_zero, pack_neg;

  always_comb begin
    prod_s = fix_dst(word_q ? prod_word : {{WORD_W{1'b0}}, prod_byte}, neg_main_q);
    quot_s = fix_word(quot_mag, neg_main_q);
    rem_s  = fix_word(rem_mag, neg_rem_q);
    if (div_q) begin
      packed_res = word_q ? {rem_s, quot_s}
                          : {dst_hi_q, rem_s[HALF_W-1:0], quot_s[HALF_W-1:0]};
      pack_zero  = word_q ? (quot_s == '0) : (quot_s[HALF_W-1:0] == '0);
      pack_neg   = word_q ? quot_s[WORD_W-1] : quot_s[HALF_W-1];
    end else begin
      packed_res = word_q ? prod_s : {dst_hi_q, prod_s[WORD_W-1:0]};
      pack_zero  = word_q ? (prod_s == '0) : (prod_s[WORD_W-1:0] == '0);
      pack_neg   = word_q ? prod_s[DST_W-1] : prod_s[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      done     <= 1'b0;
      div_zero <= 1'b0;
      res_zero <= 1'b0;
      res_neg  <= 1'b0;
    end else begin
      done     <= zero_trap || finishing;
      div_zero <= zero_trap;
      if (zero_trap) begin
        result <= dst_in;
      end else if (finishing) begin
        result   <= packed_res;
        res_zero <= pack_zero;
        res_neg  <= pack_neg;
      end
    end
  end

endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W,
  localparam int DST_W  = 4 * HALF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             div_zero,
  input logic [DST_W-1:0] dst_in,
  input logic [DST_W-1:0] result,
  input logic             res_zero,
  input logic             res_neg,
  input logic             accept,
  input logic             zero_trap,
  input logic             finishing
);

  p_trap_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_trap |=> (done && div_zero && !busy && result == $past(dst_in)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finishing) |=> $stable(result));

  p_busy_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !div_zero);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);

  p_dz_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !zero_trap) |=> (busy && !done));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !finishing |=> $stable({res_zero, res_neg}));

endmodule

bind mdu_unit mdu_unit_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .div_zero  (div_zero),
  .dst_in    (dst_in),
  .result    (result),
  .res_zero  (res_zero),
  .res_neg   (res_neg),
  .accept    (accept),
  .zero_trap (zero_trap),
  .finishing (finishing)
);

// File: tb/tb_mdu_unit.sv
module tb_mdu_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        op_div = 1'b0, op_signed = 1'b0, op_word = 1'b0;
  logic [31:0] dst_in = '0;
  logic [15:0] src_in = '0;
  logic        busy, done, div_zero, res_zero, res_neg;
  logic [31:0] result;
  string       cur_tag = "R11";

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdu_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div), .op_signed(op_signed),
    .op_word(op_word), .dst_in(dst_in), .src_in(src_in), .busy(busy), .done(done),
    .div_zero(div_zero), .result(result), .res_zero(res_zero), .res_neg(res_neg)
  );

  int vectors = 0, miscompares = 0;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Integer reference of the arithmetic
  function automatic void ref_calc(input logic d, s, w, input logic [31:0] a, input logic [15:0] b,
                                   output logic [31:0] r, output logic z, output logic n);
    longint x, y, q, m, p;
    if (!d) begin
      if (w) begin
        x = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
        y = s ? longint'($signed(b)) : longint'(b);
        p = x * y;
        r = p[31:0]; z = (p[31:0] == 0); n = p[31];
      end else begin
        x = s ? longint'($signed(a[7:0])) : longint'(a[7:0]);
        y = s ? longint'($signed(b[7:0])) : longint'(b[7:0]);
        p = x * y;
        r = {a[31:16], p[15:0]}; z = (p[15:0] == 0); n = p[15];
      end
    end else begin
      if (w) begin
        x = s ? longint'($signed(a)) : longint'(a);
        y = s ? longint'($signed(b)) : longint'(b);
      end else begin
        x = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
        y = s ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      end
      q = x / y;
      m = x % y;
      if (w) begin
        r = {m[15:0], q[15:0]}; z = (q[15:0] == 0); n = q[15];
      end else begin
        r = {a[31:16], m[7:0], q[7:0]}; z = (q[7:0] == 0); n = q[7];
      end
    end
  endfunction

  // Cycle model
  int          m_cnt = 0;
  logic        m_done = 0, m_dz = 0, m_zero = 0, m_neg = 0, m_pz = 0, m_pn = 0;
  logic [31:0] m_res = '0, m_pend = '0;
  string       m_tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_dz = 0; m_zero = 0; m_neg = 0; m_res = '0;
    end else begin
      m_done = 0;
      m_dz   = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_res = m_pend; m_zero = m_pz; m_neg = m_pn;
        end
      end else if (start) begin
        m_tag = cur_tag;
        if (op_div && (op_word ? (src_in == 16'h0) : (src_in[7:0] == 8'h0))) begin
          m_done = 1; m_dz = 1; m_res = dst_in;
        end else begin
          ref_calc(op_div, op_signed, op_word, dst_in, src_in, m_pend, m_pz, m_pn);
          m_cnt = (op_div ? (op_word ? 32 : 16) : (op_word ? 16 : 8)) + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cmp(m_tag, "R6 busy", {31'b0, busy}, {31'b0, m_cnt > 0});
      cmp(m_tag, "R9 done", {31'b0, done}, {31'b0, m_done});
      cmp(m_tag, "R9 div_zero", {31'b0, div_zero}, {31'b0, m_dz});
      cmp(m_tag, "result", result, m_res);
      cmp(m_tag, "R10 flags", {30'b0, res_zero, res_neg}, {30'b0, m_zero, m_neg});
    end
  end

  // Caller sits at a negedge; returns at the negedge where busy is low again.
  task automatic issue(input string tag, input logic d, s, w, input logic [31:0] a, input logic [15:0] b);
    cur_tag = tag;
    start = 1'b1; op_div = d; op_signed = s; op_word = w; dst_in = a; src_in = b;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    cmp("R11", "busy", {31'b0, busy}, 32'h0);
    cmp("R11", "done", {31'b0, done}, 32'h0);
    cmp("R11", "div_zero", {31'b0, div_zero}, 32'h0);
    cmp("R11", "result", result, 32'h0);
    cmp("R11", "flags", {30'b0, res_zero, res_neg}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unsigned multiply
    issue("R1", 0, 0, 0, 32'hABCD_00FF, 16'h00FF);
    issue("R1", 0, 0, 0, 32'h1234_5600, 16'h0077);
    issue("R1", 0, 0, 1, 32'h0000_FFFF, 16'hFFFF);
    issue("R1", 0, 0, 1, 32'h5555_1234, 16'h0002);
    // R2 signed multiply
    issue("R2", 0, 1, 0, 32'h0000_0080, 16'h0080);
    issue("R2", 0, 1, 0, 32'hFFFF_00FF, 16'h0001);
    issue("R2", 0, 1, 1, 32'h0000_8000, 16'h7FFF);
    issue("R2", 0, 1, 1, 32'h0000_FFFE, 16'hFFFD);
    // R3 unsigned divide
    issue("R3", 1, 0, 0, 32'h9999_03E8, 16'h0007);
    issue("R3", 1, 0, 1, 32'h000F_4240, 16'h03E7);
    // R4 signed divide
    issue("R4", 1, 1, 0, 32'h0000_FFF9, 16'h0002);
    issue("R4", 1, 1, 0, 32'h0000_0007, 16'h00FE);
    issue("R4", 1, 1, 1, 32'hFFFF_FFF9, 16'hFFFE);
    issue("R4", 1, 1, 1, 32'h0001_0001, 16'hFFF0);
    // R5 quotient overflow
    issue("R5", 1, 0, 0, 32'h0000_FFFF, 16'h0001);
    issue("R5", 1, 1, 0, 32'h0000_FF80, 16'h00FF);
    issue("R5", 1, 0, 1, 32'hFFFF_FFFF, 16'h0003);
    issue("R5", 1, 1, 1, 32'h8000_0000, 16'hFFFF);
    // R7 zero divisor, both sizes; byte checks only the low source byte
    issue("R7", 1, 0, 0, 32'hCAFE_BABE, 16'hFF00);
    issue("R7", 1, 1, 1, 32'h1357_9BDF, 16'h0000);
    // R8 start while busy: a zero-divisor request and a multiply are both ignored
    cur_tag = "R8";
    start = 1'b1; op_div = 1; op_signed = 0; op_word = 1; dst_in = 32'h0012_3456; src_in = 16'h0100;
    @(negedge clk);
    op_div = 1; dst_in = 32'hDEAD_BEEF; src_in = 16'h0000;
    repeat (3) @(negedge clk);
    op_div = 0; src_in = 16'h0011;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    // R9 back-to-back: zero-divisor traps and a multiply launched on done cycles
    issue("R9", 1, 0, 0, 32'h0000_1111, 16'h0000);
    issue("R9", 1, 0, 0, 32'h0000_2222, 16'h0000);
    issue("R9", 0, 0, 0, 32'h0000_0000, 16'h0055);
    issue("R10", 0, 1, 0, 32'h0000_0003, 16'h00FF);
    // random mix covers R1-style to R4-style patterns
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra;
      logic [15:0] rb;
      logic [2:0]  rc;
      ra = $urandom;
      rb = $urandom;
      rc = 3'($urandom);
      if (rc[0] && (rb[7:0] == 8'h0)) rb[0] = 1'b1;
      issue(rc[0] ? (rc[1] ? "R4" : "R3") : (rc[1] ? "R2" : "R1"), rc[0], rc[1], rc[2], ra, rb);
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule